// File: doc/BRIEF.md
# Event Counter Bank with Overflow Signalling

This block keeps a set of programmable event counters for a processor core. It has `NUM_GP` general-purpose counters, each steered by its own 32-bit selector register, and `NUM_FIX` fixed-function counters. The fixed counters are steered by one shared control word that holds a 4-bit field per counter. Every cycle the core presents a small count for each of `NUM_EV` event lines, and one mode flag telling whether the core ran in user or kernel mode that cycle. A counter adds the events of its line when three things agree: its own enable, its bit in the global enable register, and its mode filter.

A counter that wraps past all-ones sets a sticky bit in the global status register. Software clears that bit by writing a one to the status-clear address. A single level interrupt line is high while any status bit whose counter has its interrupt enabled stays set. Every register can be reached through a plain word-wide read/write port: reads are combinational and writes are single-cycle.

Address map (`bus_addr`): `0x00+i` holds general counter i, `0x10+i` holds selector i, `0x20+j` holds fixed counter j, `0x30` is the fixed control word, `0x31` is global enable, `0x32` is global status (read only), and `0x33` is status clear (write only). Global bit i belongs to general counter i. Global bit `FIX_BASE+j` belongs to fixed counter j.

Top module: `perf_counter_bank`

## Requirements
- R1: After reset every counter, selector, the fixed control word, global enable and global status read zero, and `irq` is low.
- R2: General counter i adds the count of event line `sel[7:0]` in a cycle only when selector bit 22 (enable) and global bit i are both set, and the mode filter passes: bit 16 admits user-mode cycles (`ev_user`=1) and bit 17 admits kernel-mode cycles. Otherwise it holds its value.
- R3: Fixed counter j counts event line j. Its field sits at bits 4j+3:4j of the control word: bit 0 admits kernel mode, bit 1 admits user mode, and bit 3 enables its interrupt. It also needs global bit `FIX_BASE+j` (default 32).
- R4: Counters are `CW` bits wide (default 48) and wrap modulo 2^CW. A wrap sets the counter's global status bit. A counter preset to 2^CW+1−K reads 1 after K single increments.
- R5: Status bits are sticky. Writing `0x33` clears exactly the bits written as one, and zero bits leave status unchanged.
- R6: `irq` is high while a status bit is set whose interrupt enable is set (selector bit 20, or fixed field bit 3). A wrap without interrupt enable sets status but leaves `irq` low. Clearing the bit drops `irq`.
- R7: When selector bits 31:24 (threshold) are non-zero, the counter adds 1 only in cycles where its line's count is at least the threshold, and 0 otherwise.
- R8: A write to a running counter takes effect on the next edge. Later increments, including a wrap that sets status, continue from the written value. A write and an increment to the same counter in one cycle leave the written value.
- R9: Selectors, the fixed control word and global enable read back as written. Counter writes keep only the low `CW` bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ev_cnt | input | NUM_EV*EVW | Per-cycle event count of each line, line k at bits k*EVW +: EVW |
| ev_user | input | 1 | 1 = current cycle is user mode, 0 = kernel mode |
| bus_addr | input | 8 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 64 | Write data |
| bus_rdata | output | 64 | Read data for `bus_addr`, combinational |
| irq | output | 1 | Level overflow interrupt |

## Verification
A wrong internal counter value shows up in the very next read of that counter's address. If it crosses all-ones at the wrong time, the status word and `irq` flip one edge early or late, which the bench sees on the cycle after the stimulus. A corrupted status or interrupt-enable bit shows on `irq` at once, because the line is combinational from those registers. Gating faults in the enable, mode or threshold logic leave a counter that differs from its expected sum after a short burst of events.

// File: rtl/pcb_pkg.sv
// Package: shared constants for the event counter bank.
// Assumes a 64-bit register port and 8-bit addresses split as region:index.
package pcb_pkg;
    localparam int DW      = 64;
    localparam int SEL_W   = 32;
    // address regions (upper nibble of bus_addr)
    localparam logic [3:0] RG_GPCNT = 4'h0;
    localparam logic [3:0] RG_GPSEL = 4'h1;
    localparam logic [3:0] RG_FXCNT = 4'h2;
    localparam logic [3:0] RG_MISC  = 4'h3;
    // misc region indices
    localparam logic [3:0] IX_FCTL  = 4'h0;
    localparam logic [3:0] IX_GEN   = 4'h1;
    localparam logic [3:0] IX_STAT  = 4'h2;
    localparam logic [3:0] IX_CLR   = 4'h3;
    // selector bit positions
    localparam int SB_USER  = 16;
    localparam int SB_KERN  = 17;
    localparam int SB_INT   = 20;
    localparam int SB_EN    = 22;
    localparam int SB_THR_L = 24;
    // fixed field bit positions
    localparam int FB_KERN  = 0;
    localparam int FB_USER  = 1;
    localparam int FB_INT   = 3;
endpackage

// File: rtl/pcb_gp_gate.sv
// Module: pcb_gp_gate
// Turns one selector word plus the event inputs into the increment for a
// general counter. Applies line choice, enable, global enable, mode filter
// and the threshold. Assumes EVW <= 8 so a count fits the threshold field.
module pcb_gp_gate
    import pcb_pkg::*;
#(
    parameter int NUM_EV = 4,
    parameter int EVW    = 4
) (
    input  logic [SEL_W-1:0]      sel,
    input  logic                  glb_en,
    input  logic [NUM_EV*EVW-1:0] ev_cnt,
    input  logic                  ev_user,
    output logic [EVW-1:0]        inc
);
    logic [EVW-1:0] line_cnt;
    logic [7:0]     thr;
    logic           live;

    // pick the event line named by the selector code
    always_comb begin
        line_cnt = '0;
        for (int k = 0; k < NUM_EV; k++) begin
            if (sel[7:0] == 8'(k)) line_cnt = ev_cnt[k*EVW +: EVW];
        end
    end

    assign thr  = sel[SB_THR_L +: 8];
    assign live = glb_en && sel[SB_EN] &&
                  (ev_user ? sel[SB_USER] : sel[SB_KERN]);

    // raw count, or a single step when the threshold is met
    always_comb begin
        if (!live)
            inc = '0;
        else if (thr == 8'd0)
            inc = line_cnt;
        else
            inc = (8'(line_cnt) >= thr) ? {{(EVW-1){1'b0}}, 1'b1} : '0;
    end
endmodule

// File: rtl/pcb_counter.sv
// Module: pcb_counter
// One CW-bit wrapping counter with a write port that takes priority over
// the increment. Reports a wrap combinationally in the cycle it happens.
// Assumes IW < CW.
module pcb_counter #(
    parameter int CW = 48,
    parameter int IW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr,
    input  logic [CW-1:0] wr_val,
    input  logic [IW-1:0] inc,
    output logic [CW-1:0] val,
    output logic          ovf
);
    logic [CW:0] sum;

    assign sum = {1'b0, val} + (CW+1)'(inc);
    assign ovf = !wr && sum[CW];

    // hold, load from the register port, or advance modulo 2^CW
    always_ff @(posedge clk) begin
        if (!rst_n)
            val <= '0;
        else if (wr)
            val <= wr_val;
        else
            val <= sum[CW-1:0];
    end

    // R8: a written value is what appears after the edge
    p_write_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(wr) |-> val == $past(wr_val));
    // R4: a wrap always lands below the value it started from
    p_wrap_drops_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |=> val < $past(val));
endmodule

// File: rtl/perf_counter_bank.sv
// Module: perf_counter_bank (top)
// Bank of NUM_GP selectable counters and NUM_FIX fixed counters with global
// enable, sticky overflow status, write-one-to-clear and a level interrupt.
// Assumes NUM_GP <= FIX_BASE, FIX_BASE + NUM_FIX <= 64, NUM_GP and
// NUM_FIX <= 16, CW <= 64, EVW <= 8.
module perf_counter_bank
    import pcb_pkg::*;
#(
    parameter int NUM_GP   = 4,
    parameter int NUM_FIX  = 3,
    parameter int NUM_EV   = 4,
    parameter int EVW      = 4,
    parameter int CW       = 48,
    parameter int FIX_BASE = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_EV*EVW-1:0] ev_cnt,
    input  logic                  ev_user,
    input  logic [7:0]            bus_addr,
    input  logic                  bus_wr,
    input  logic [DW-1:0]         bus_wdata,
    output logic [DW-1:0]         bus_rdata,
    output logic                  irq
);
    localparam int FCW = 4 * NUM_FIX;

    logic [3:0]       rg, ix;
    logic [SEL_W-1:0] sel_q [NUM_GP];
    logic [FCW-1:0]   fctl_q;
    logic [DW-1:0]    gen_q, stat_q, ovf_vec, ien_vec, clr_mask;
    logic [CW-1:0]    gp_val [NUM_GP];
    logic [CW-1:0]    fx_val [NUM_FIX];
    logic [EVW-1:0]   gp_inc [NUM_GP];
    logic [EVW-1:0]   fx_inc [NUM_FIX];
    logic             gp_ovf [NUM_GP];
    logic             fx_ovf [NUM_FIX];

    assign rg       = bus_addr[7:4];
    assign ix       = bus_addr[3:0];
    assign clr_mask = (bus_wr && rg == RG_MISC && ix == IX_CLR) ? bus_wdata : '0;

    genvar g;
    generate
        for (g = 0; g < NUM_GP; g++) begin : gp
            logic sel_wr, cnt_wr;
            assign sel_wr = bus_wr && rg == RG_GPSEL && ix == 4'(g);
            assign cnt_wr = bus_wr && rg == RG_GPCNT && ix == 4'(g);

            // selector register for this counter
            always_ff @(posedge clk) begin
                if (!rst_n)      sel_q[g] <= '0;
                else if (sel_wr) sel_q[g] <= bus_wdata[SEL_W-1:0];
            end

            pcb_gp_gate #(.NUM_EV(NUM_EV), .EVW(EVW)) u_gate (
                .sel(sel_q[g]), .glb_en(gen_q[g]), .ev_cnt(ev_cnt),
                .ev_user(ev_user), .inc(gp_inc[g]));

            pcb_counter #(.CW(CW), .IW(EVW)) u_cnt (
                .clk(clk), .rst_n(rst_n), .wr(cnt_wr),
                .wr_val(bus_wdata[CW-1:0]), .inc(gp_inc[g]),
                .val(gp_val[g]), .ovf(gp_ovf[g]));

            // R7: a thresholded selector advances by at most one per cycle
            p_thr_unit_r7: assert property (@(posedge clk) disable iff (!rst_n)
                sel_q[g][SB_THR_L +: 8] != 8'd0 |-> gp_inc[g] <= EVW'(1));
            // R2: no advance while the global bit is clear
            p_glb_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
                !gen_q[g] |-> gp_inc[g] == '0);
        end

        for (g = 0; g < NUM_FIX; g++) begin : fx
            logic cnt_wr, on;
            assign cnt_wr = bus_wr && rg == RG_FXCNT && ix == 4'(g);
            assign on = gen_q[FIX_BASE+g] &&
                        (ev_user ? fctl_q[4*g+FB_USER] : fctl_q[4*g+FB_KERN]);
            assign fx_inc[g] = on ? ev_cnt[(g % NUM_EV)*EVW +: EVW] : '0;

            pcb_counter #(.CW(CW), .IW(EVW)) u_cnt (
                .clk(clk), .rst_n(rst_n), .wr(cnt_wr),
                .wr_val(bus_wdata[CW-1:0]), .inc(fx_inc[g]),
                .val(fx_val[g]), .ovf(fx_ovf[g]));
        end
    endgenerate

    // gather wrap flags and interrupt enables onto global bit positions
    always_comb begin
        ovf_vec = '0;
        ien_vec = '0;
        for (int i = 0; i < NUM_GP; i++) begin
            ovf_vec[i] = gp_ovf[i];
            ien_vec[i] = sel_q[i][SB_INT];
        end
        for (int j = 0; j < NUM_FIX; j++) begin
            ovf_vec[FIX_BASE+j] = fx_ovf[j];
            ien_vec[FIX_BASE+j] = fctl_q[4*j+FB_INT];
        end
    end

    // fixed control word and global enable registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fctl_q <= '0;
            gen_q  <= '0;
        end else if (bus_wr && rg == RG_MISC) begin
            if (ix == IX_FCTL) fctl_q <= bus_wdata[FCW-1:0];
            if (ix == IX_GEN)  gen_q  <= bus_wdata;
        end
    end

    // sticky status: clear by mask, then new wraps win
    always_ff @(posedge clk) begin
        if (!rst_n) stat_q <= '0;
        else        stat_q <= (stat_q & ~clr_mask) | ovf_vec;
    end

    assign irq = |(stat_q & ien_vec);

    // combinational register read mux
    always_comb begin
        bus_rdata = '0;
        case (rg)
            RG_GPCNT: for (int i = 0; i < NUM_GP; i++)
                          if (ix == 4'(i)) bus_rdata = DW'(gp_val[i]);
            RG_GPSEL: for (int i = 0; i < NUM_GP; i++)
                          if (ix == 4'(i)) bus_rdata = DW'(sel_q[i]);
            RG_FXCNT: for (int j = 0; j < NUM_FIX; j++)
                          if (ix == 4'(j)) bus_rdata = DW'(fx_val[j]);
            RG_MISC: begin
                if (ix == IX_FCTL) bus_rdata = DW'(fctl_q);
                if (ix == IX_GEN)  bus_rdata = gen_q;
                if (ix == IX_STAT) bus_rdata = stat_q;
            end
            default: bus_rdata = '0;
        endcase
    end

    // R5: a set status bit survives unless its clear bit was written
    p_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (($past(stat_q) & ~$past(clr_mask)) & ~stat_q) == '0);
    // R6: the interrupt line is never high with an empty status word
    p_irq_has_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> stat_q != '0);
    // R4: any wrap is visible in status on the following cycle
    p_wrap_sets_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_vec != '0 |=> (stat_q & $past(ovf_vec)) == $past(ovf_vec));
endmodule

// File: tb/perf_counter_bank_test.sv
`timescale 1ns/1ps
module perf_counter_bank_test;
    localparam int NUM_EV = 4;
    localparam int EVW    = 4;

    typedef struct {
        bit          is_irq;
        logic [7:0]  addr;
        logic [63:0] exp;
        string       tag;
    } item_t;

    logic                  clk = 0;
    logic                  rst_n = 0;
    logic [NUM_EV*EVW-1:0] ev_cnt = '0;
    logic                  ev_user = 0;
    logic [7:0]            bus_addr = '0;
    logic                  bus_wr = 0;
    logic [63:0]           bus_wdata = '0;
    logic [63:0]           bus_rdata;
    logic                  irq;

    item_t q[$];
    int checks = 0;
    int errors = 0;
    bit done = 0;

    localparam logic [63:0] ONES48 = 64'h0000_FFFF_FFFF_FFFF;

    always #10 clk = ~clk;

    perf_counter_bank uut (
        .clk(clk), .rst_n(rst_n), .ev_cnt(ev_cnt), .ev_user(ev_user),
        .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq(irq));

    // monitor: pop an expected item and compare just after the edge
    always @(posedge clk) begin
        #1;
        if (q.size() != 0) begin
            item_t it;
            logic [63:0] act;
            it = q.pop_front();
            act = it.is_irq ? {63'b0, irq} : bus_rdata;
            checks++;
            if (act !== it.exp) begin
                errors++;
                $display("FAIL %s addr %h actual %h expected %h",
                         it.tag, it.addr, act, it.exp);
            end
        end
    end

    task automatic exp_reg(input logic [7:0] a, input logic [63:0] e, input string tag);
        @(negedge clk);
        bus_addr = a; bus_wr = 0; ev_cnt = '0;
        q.push_back('{1'b0, a, e, tag});
    endtask

    task automatic exp_irq(input bit e, input string tag);
        @(negedge clk);
        bus_wr = 0; ev_cnt = '0;
        q.push_back('{1'b1, 8'h00, {63'b0, e}, tag});
    endtask

    task automatic wr_reg(input logic [7:0] a, input logic [63:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1;
        @(negedge clk);
        bus_wr = 0;
    endtask

    task automatic pulse(input logic [15:0] ev, input bit user);
        @(negedge clk);
        ev_cnt = ev; ev_user = user;
        @(negedge clk);
        ev_cnt = '0;
    endtask

    task automatic wr_with_ev(input logic [7:0] a, input logic [63:0] d,
                              input logic [15:0] ev, input bit user);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1; ev_cnt = ev; ev_user = user;
        @(negedge clk);
        bus_wr = 0; ev_cnt = '0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1;

        // R1 reset state
        exp_reg(8'h00, 64'h0, "R1 gp0 reset");
        exp_reg(8'h10, 64'h0, "R1 sel0 reset");
        exp_reg(8'h31, 64'h0, "R1 global enable reset");
        exp_reg(8'h32, 64'h0, "R1 status reset");
        exp_irq(1'b0, "R1 irq reset");

        // R9 selector readback, R2 gating
        wr_reg(8'h10, 64'h0043_0001);
        exp_reg(8'h10, 64'h0043_0001, "R9 sel0 readback");
        pulse(16'h0030, 1);
        exp_reg(8'h00, 64'd0, "R2 global bit clear holds");
        wr_reg(8'h31, 64'h1);
        exp_reg(8'h31, 64'h1, "R9 global enable readback");
        pulse(16'h0030, 1);
        exp_reg(8'h00, 64'd3, "R2 counts selected line");
        pulse(16'h0005, 1);
        exp_reg(8'h00, 64'd3, "R2 other line ignored");
        wr_reg(8'h11, 64'h0041_0002);
        wr_reg(8'h31, 64'h3);
        pulse(16'h0400, 0);
        exp_reg(8'h01, 64'd0, "R2 kernel cycle filtered");
        pulse(16'h0400, 1);
        exp_reg(8'h01, 64'd4, "R2 user cycle counted");
        wr_reg(8'h10, 64'h0003_0001);
        pulse(16'h0030, 1);
        exp_reg(8'h00, 64'd3, "R2 own enable clear holds");
        wr_reg(8'h10, 64'h0043_0001);

        // R7 threshold against plain counting
        wr_reg(8'h12, 64'h0243_0003);
        wr_reg(8'h13, 64'h0043_0003);
        wr_reg(8'h31, 64'hF);
        pulse(16'h1000, 1);
        pulse(16'h3000, 1);
        pulse(16'h2000, 1);
        exp_reg(8'h12, 64'h0243_0003, "R9 sel2 readback");
        exp_reg(8'h02, 64'd2, "R7 threshold 2 count");
        exp_reg(8'h03, 64'd6, "R7 unthresholded count");

        // R4 preset 1-K wraps to 1, R6 no irq without enable, R5 clear
        wr_reg(8'h00, ONES48 - 64'd1);
        pulse(16'h0010, 1);
        pulse(16'h0010, 1);
        pulse(16'h0010, 1);
        exp_reg(8'h00, 64'd1, "R4 preset wrap reads 1");
        exp_reg(8'h32, 64'h1, "R4 wrap sets status");
        exp_irq(1'b0, "R6 no irq without enable");
        wr_reg(8'h33, 64'h0);
        exp_reg(8'h32, 64'h1, "R5 zero clear keeps status");
        wr_reg(8'h33, 64'h1);
        exp_reg(8'h32, 64'h0, "R5 one clears status");

        // R6 interrupt level and drop
        wr_reg(8'h11, 64'h0051_0002);
        wr_reg(8'h01, ONES48);
        pulse(16'h0100, 1);
        exp_reg(8'h01, 64'd0, "R4 all-ones wraps to zero");
        exp_reg(8'h32, 64'h2, "R6 status bit1");
        exp_irq(1'b1, "R6 irq raised");
        exp_irq(1'b1, "R6 irq held");
        wr_reg(8'h33, 64'h2);
        exp_irq(1'b0, "R6 irq dropped on clear");

        // R3 fixed counters
        wr_reg(8'h30, 64'h29);
        exp_reg(8'h30, 64'h29, "R9 fixed control readback");
        wr_reg(8'h31, 64'h3_0000_000F);
        pulse(16'h0052, 0);
        exp_reg(8'h20, 64'd2, "R3 fixed0 kernel counts");
        exp_reg(8'h21, 64'd0, "R3 fixed1 kernel filtered");
        pulse(16'h0052, 1);
        exp_reg(8'h20, 64'd2, "R3 fixed0 user filtered");
        exp_reg(8'h21, 64'd5, "R3 fixed1 user counts");
        exp_reg(8'h22, 64'd0, "R3 fixed2 disabled");
        wr_reg(8'h20, ONES48);
        pulse(16'h0001, 0);
        exp_reg(8'h32, 64'h1_0000_0000, "R3 fixed0 status at base bit");
        exp_irq(1'b1, "R3 fixed interrupt bit");
        wr_reg(8'h33, 64'h1_0000_0000);
        exp_irq(1'b0, "R6 fixed irq cleared");

        // R8 write against running counter
        wr_with_ev(8'h03, 64'd100, 16'h2000, 1);
        exp_reg(8'h03, 64'd100, "R8 write wins same cycle");
        pulse(16'h2000, 1);
        exp_reg(8'h03, 64'd102, "R8 counts on from write");
        wr_reg(8'h03, ONES48);
        pulse(16'h1000, 1);
        exp_reg(8'h03, 64'd0, "R8 wrap after write");
        exp_reg(8'h32, 64'h8, "R8 wrap after write sets status");
        exp_irq(1'b0, "R6 bit3 no interrupt");

        // R9 truncation to counter width
        wr_reg(8'h03, 64'hFFFF_0000_0000_0005);
        exp_reg(8'h03, 64'h5, "R9 write truncated to width");

        @(negedge clk);
        @(negedge clk);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule